// File: doc/BRIEF.md
# Open-Row SDRAM Burst Controller

The block sits between a processor bus and one SDRAM device. Both run on the same clock. Every processor transfer is a four-beat burst. The block keeps a valid flag and the last activated row for each SDRAM bank, so a row stays open after an access. When a request arrives, its row is compared with the open row of the addressed bank, and the result picks one of three paths:

- **Row match:** the column command is issued at once.
- **Bank closed:** only ACTIVATE is issued, followed by the column command.
- **Other row open:** the bank is precharged, the new row is activated, and then the column command is issued.

Column commands never ask for auto-precharge, so the row stays open for the next request. This makes the time to the first beat depend on what is already open in the bank.

The host starts a transfer with a one-cycle strobe while `cpu_busy` is low. It then exchanges data on the cycles where `cpu_beat` is high. The three timing values come from a configuration word: CAS latency (2 or 3), activate-to-column delay, and precharge-to-activate delay. A refresh request is taken only between bursts. It closes every bank with a precharge-all and then issues an auto-refresh.

Top module: `sdram_page_ctrl`

## Requirements
- R1: After reset the SDRAM pins show NOP, `cpu_busy`, `cpu_beat` and `sd_dq_oe` are low, and every bank counts as closed.
- R2: Commands are encoded on {cs_n, ras_n, cas_n, we_n} as follows: NOP 0111, ACTIVATE 0011, READ 0101, WRITE 0100, PRECHARGE 0010, AUTO-REFRESH 0001.
- R3: A request whose row equals the open row of its bank issues READ or WRITE in the first cycle after the strobe. The first write beat is in that same cycle, and the first read beat follows CL cycles later.
- R4: A request to an open bank with a different row issues PRECHARGE to that bank first, then ACTIVATE tRP cycles later, then the column command tRCD cycles after that.
- R5: A request to a closed bank issues ACTIVATE first, then the column command tRCD cycles later.
- R6: Every burst has exactly four consecutive `cpu_beat` cycles.
- R7: On column commands `sd_addr[10]` is 0, so auto-precharge stays off. The column sits in the low bits of `sd_addr`.
- R8: `cfg_cas3`=0 selects CAS latency 2, and `cfg_cas3`=1 selects CAS latency 3.
- R9: A strobe while `cpu_busy` is high is ignored: it issues no command and opens no bank.
- R10: `ref_req` is served only when the block is idle, and it takes priority over a strobe in the same cycle. Service is PRECHARGE with `sd_addr[10]`=1, then AUTO-REFRESH tRP cycles later with `ref_ack` high. Afterwards every bank counts as closed.
- R11: On write beats `sd_dq_oe` is high and `sd_dq_out` equals `cpu_wdata`. On read beats `cpu_rdata` equals `sd_dq_in`.
- R12: Open rows are tracked per bank. A bank's state is changed only by accesses to that bank and by refresh.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Shared bus and SDRAM clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cpu_start | input | 1 | Request strobe, taken when idle |
| cpu_write | input | 1 | 1 = write burst, 0 = read burst |
| cpu_addr | input | 24 | Word address {row, bank, column} |
| cpu_wdata | input | 32 | Write data for the current beat |
| cpu_rdata | output | 32 | Read data for the current beat |
| cpu_busy | output | 1 | High while a request or refresh runs |
| cpu_beat | output | 1 | Data beat in this cycle |
| ref_req | input | 1 | Refresh request |
| ref_ack | output | 1 | High in the AUTO-REFRESH cycle |
| cfg_cas3 | input | 1 | CAS latency select |
| cfg_trcd | input | 4 | Activate-to-column delay in clocks |
| cfg_trp | input | 4 | Precharge-to-activate delay in clocks |
| sd_cs_n | output | 1 | Chip select |
| sd_ras_n | output | 1 | Row strobe |
| sd_cas_n | output | 1 | Column strobe |
| sd_we_n | output | 1 | Write enable |
| sd_ba | output | 2 | Bank address |
| sd_addr | output | 13 | Row or column address, bit 10 selects auto-precharge or all banks |
| sd_dq_out | output | 32 | Write data to SDRAM |
| sd_dq_oe | output | 1 | Data drive enable |
| sd_dq_in | input | 32 | Read data from SDRAM |

## Verification
Several behaviours are checked by assertions on every cycle:
- each burst is exactly four beats;
- column commands never set bit 10;
- ACTIVATE targets only a bank marked closed;
- column commands target only a bank marked open;
- AUTO-REFRESH occurs only when every bank is closed.

Other behaviours need the bench's scenarios: the cycle count from strobe to first beat for a row match, a closed bank and a row conflict under different CAS latency, tRCD and tRP settings. The same holds for dropping strobes during a burst and for the closed state left by a refresh. These show up only as latency and command order at the pins.

// File: rtl/sdram_page_ctrl.sv
module sdram_page_ctrl #(
  parameter int ROWW  = 13,
  parameter int COLW  = 9,
  parameter int BANKW = 2,
  parameter int DW    = 32,
  parameter int TRFC  = 6
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         cpu_start,
  input  logic                         cpu_write,
  input  logic [ROWW+BANKW+COLW-1:0]   cpu_addr,
  input  logic [DW-1:0]                cpu_wdata,
  output logic [DW-1:0]                cpu_rdata,
  output logic                         cpu_busy,
  output logic                         cpu_beat,
  input  logic                         ref_req,
  output logic                         ref_ack,
  input  logic                         cfg_cas3,
  input  logic [3:0]                   cfg_trcd,
  input  logic [3:0]                   cfg_trp,
  output logic                         sd_cs_n,
  output logic                         sd_ras_n,
  output logic                         sd_cas_n,
  output logic                         sd_we_n,
  output logic [BANKW-1:0]             sd_ba,
  output logic [ROWW-1:0]              sd_addr,
  output logic [DW-1:0]                sd_dq_out,
  output logic                         sd_dq_oe,
  input  logic [DW-1:0]                sd_dq_in
);
  localparam int NB = 1 << BANKW;
  localparam int AW = ROWW + BANKW + COLW;
  localparam int AP = 10;

  typedef enum logic [2:0] {S_IDLE, S_PRE, S_ACT, S_COL, S_WAIT, S_BURST, S_RPALL, S_REF} st_t;

  st_t state, ret, tgt;
  logic [7:0] cnt, dly;
  logic [1:0] beat_n;
  logic wr_q;
  logic [ROWW-1:0]  row_q;
  logic [BANKW-1:0] bank_q;
  logic [COLW-1:0]  col_q;
  logic [NB-1:0]    open_v;
  logic [ROWW-1:0]  open_row [NB];

  wire [ROWW-1:0]  a_row  = cpu_addr[AW-1 -: ROWW];
  wire [BANKW-1:0] a_bank = cpu_addr[COLW +: BANKW];
  wire [COLW-1:0]  a_col  = cpu_addr[COLW-1:0];
  wire hit = open_v[a_bank] && (open_row[a_bank] == a_row);
  wire [7:0] cl = cfg_cas3 ? 8'd3 : 8'd2;

  always_comb begin
    dly = 8'd1;
    tgt = S_IDLE;
    case (state)
      S_PRE:   begin dly = {4'd0, cfg_trp};  tgt = S_ACT;   end
      S_ACT:   begin dly = {4'd0, cfg_trcd}; tgt = S_COL;   end
      S_COL:   begin dly = wr_q ? 8'd1 : cl; tgt = S_BURST; end
      S_RPALL: begin dly = {4'd0, cfg_trp};  tgt = S_REF;   end
      S_REF:   begin dly = 8'(TRFC);         tgt = S_IDLE;  end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state  <= S_IDLE;
      ret    <= S_IDLE;
      cnt    <= '0;
      beat_n <= '0;
      wr_q   <= 1'b0;
      row_q  <= '0;
      bank_q <= '0;
      col_q  <= '0;
      open_v <= '0;
      for (int i = 0; i < NB; i++) open_row[i] <= '0;
    end else begin
      case (state)
        S_IDLE: begin
          if (ref_req) state <= S_RPALL;
          else if (cpu_start) begin
            wr_q   <= cpu_write;
            row_q  <= a_row;
            bank_q <= a_bank;
            col_q  <= a_col;
            state  <= hit ? S_COL : (open_v[a_bank] ? S_PRE : S_ACT);
          end
        end
        S_WAIT: begin
          if (cnt == 0) state <= ret;
          else cnt <= cnt - 8'd1;
        end
        S_BURST: begin
          beat_n <= beat_n + 2'd1;
          if (beat_n == 2'd3) state <= S_IDLE;
        end
        default: begin
          if (dly <= 8'd1) state <= tgt;
          else begin
            state <= S_WAIT;
            ret   <= tgt;
            cnt   <= dly - 8'd2;
          end
          case (state)
            S_PRE:   open_v[bank_q] <= 1'b0;
            S_ACT:   begin open_v[bank_q] <= 1'b1; open_row[bank_q] <= row_q; end
            S_COL:   beat_n <= wr_q ? 2'd1 : 2'd0;
            S_RPALL: open_v <= '0;
            default: ;
          endcase
        end
      endcase
    end
  end

  always_comb begin
    {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0111;
    sd_ba   = bank_q;
    sd_addr = '0;
    case (state)
      S_ACT:   begin {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0011; sd_addr = row_q; end
      S_COL:   begin
        {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = wr_q ? 4'b0100 : 4'b0101;
        sd_addr[COLW-1:0] = col_q;
      end
      S_PRE:   {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0010;
      S_RPALL: begin {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0010; sd_addr[AP] = 1'b1; end
      S_REF:   {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n} = 4'b0001;
      default: ;
    endcase
  end

  assign cpu_busy  = (state != S_IDLE);
  assign cpu_beat  = (state == S_BURST) || (state == S_COL && wr_q);
  assign ref_ack   = (state == S_REF);
  assign sd_dq_oe  = cpu_beat && wr_q;
  assign sd_dq_out = cpu_wdata;
  assign cpu_rdata = sd_dq_in;

  wire is_act = !sd_cs_n && !sd_ras_n &&  sd_cas_n &&  sd_we_n;
  wire is_col = !sd_cs_n &&  sd_ras_n && !sd_cas_n;
  wire is_ref = !sd_cs_n && !sd_ras_n && !sd_cas_n &&  sd_we_n;

  a_r6_four_beats: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_beat) |=> cpu_beat ##1 cpu_beat ##1 cpu_beat ##1 !cpu_beat);
  a_r7_no_autopre: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> !sd_addr[AP]);
  a_r5_act_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_act |-> !open_v[sd_ba]);
  a_r3_col_open: assert property (@(posedge clk) disable iff (!rst_n)
    is_col |-> open_v[sd_ba]);
  a_r10_ref_closed: assert property (@(posedge clk) disable iff (!rst_n)
    is_ref |-> (open_v == '0));
endmodule

// File: tb/sim_sdram_page_ctrl.sv
module sim_sdram_page_ctrl;
  localparam int ROWW = 13, COLW = 9, BANKW = 2, DW = 32;
  localparam int AW = ROWW + BANKW + COLW;
  localparam int VW = 1 + ROWW + BANKW + COLW + 4 + 4;
  localparam int NV = 8;
  // {write, row, bank, col, first-beat latency, first command}
  localparam logic [VW-1:0] VEC [NV] = '{
    {1'b0, 13'd5, 2'd0, 9'd3,  4'd5, 4'b0011},  // R5 closed read
    {1'b0, 13'd5, 2'd0, 9'd40, 4'd3, 4'b0101},  // R3 hit read
    {1'b1, 13'd5, 2'd0, 9'd8,  4'd1, 4'b0100},  // R3 hit write
    {1'b0, 13'd5, 2'd1, 9'd1,  4'd5, 4'b0011},  // R12 other bank closed
    {1'b0, 13'd7, 2'd0, 9'd2,  4'd7, 4'b0010},  // R4 miss read
    {1'b1, 13'd5, 2'd0, 9'd9,  4'd5, 4'b0010},  // R4 miss write
    {1'b1, 13'd5, 2'd1, 9'd77, 4'd1, 4'b0100},  // R12 bank1 still open
    {1'b1, 13'd1, 2'd2, 9'd4,  4'd3, 4'b0011}   // R5 closed write
  };

  logic clk = 0, rst_n = 0;
  logic cpu_start = 0, cpu_write = 0, ref_req = 0, cfg_cas3 = 0;
  logic [AW-1:0] cpu_addr = '0;
  logic [DW-1:0] cpu_wdata = '0, sd_dq_in = '0;
  logic [3:0] cfg_trcd = 4'd2, cfg_trp = 4'd2;
  logic [DW-1:0] cpu_rdata, sd_dq_out;
  logic cpu_busy, cpu_beat, ref_ack, sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n, sd_dq_oe;
  logic [BANKW-1:0] sd_ba;
  logic [ROWW-1:0] sd_addr;
  int checks = 0, fails = 0;
  bit done = 0;

  always #5 clk = ~clk;

  sdram_page_ctrl u0 (.*);

  wire [3:0] cmd = {sd_cs_n, sd_ras_n, sd_cas_n, sd_we_n};

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [ROWW-1:0] row, input logic [BANKW-1:0] bank,
                        input logic [COLW-1:0] col, input int lat, input logic [3:0] fcmd);
    int n;
    @(negedge clk);
    cpu_start = 1; cpu_write = w; cpu_addr = {row, bank, col};
    @(negedge clk);
    cpu_start = 0; n = 1;
    chk(cmd == fcmd, "R2 first command", cmd, fcmd);
    if (fcmd == 4'b0010) chk(sd_ba == bank && !sd_addr[10], "R4 bank precharge", sd_ba, bank);
    forever begin
      if (cmd == 4'b0011) chk(sd_addr == row && sd_ba == bank, "R5 activate row", sd_addr, row);
      if (cmd == 4'b0101 || cmd == 4'b0100) begin
        chk(!sd_addr[10], "R7 auto-precharge off", sd_addr[10], 0);
        chk(sd_addr[COLW-1:0] == col, "R7 column", sd_addr[COLW-1:0], col);
      end
      if (cpu_beat || n > 40) break;
      @(negedge clk); n++;
    end
    chk(n == lat, "R3 R4 R5 R8 first-beat latency", n, lat);
    for (int k = 0; k < 4; k++) begin
      cpu_wdata = 32'hC0DE0000 + k;
      sd_dq_in  = 32'h00001000 + k;
      #1;
      chk(cpu_beat, "R6 beat run", cpu_beat, 1);
      if (w) chk(sd_dq_oe && sd_dq_out == cpu_wdata, "R11 write data", sd_dq_out, cpu_wdata);
      else   chk(!sd_dq_oe && cpu_rdata == sd_dq_in, "R11 read data", cpu_rdata, sd_dq_in);
      @(negedge clk);
    end
    chk(!cpu_beat && !cpu_busy, "R6 burst end", cpu_beat, 0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    int nb;
    repeat (3) @(negedge clk);
    chk(cmd == 4'b0111, "R1 reset NOP", cmd, 4'b0111);
    chk(!cpu_busy && !cpu_beat && !sd_dq_oe, "R1 reset outputs", {cpu_busy, cpu_beat, sd_dq_oe}, 0);
    rst_n = 1;

    for (int i = 0; i < NV; i++) begin
      logic [VW-1:0] v;
      v = VEC[i];
      access(v[VW-1], v[VW-2 -: ROWW], v[8+COLW +: BANKW], v[8 +: COLW], int'(v[7:4]), v[3:0]);
    end

    // R9: strobes during a hit read are dropped
    @(negedge clk);
    cpu_start = 1; cpu_write = 0; cpu_addr = {13'd5, 2'd0, 9'd7};
    nb = 0;
    for (int i = 1; i <= 8; i++) begin
      @(negedge clk);
      if (i <= 3) begin cpu_start = 1; cpu_write = 1; cpu_addr = {13'd0, 2'd3, 9'd0}; end
      else cpu_start = 0;
      #1;
      if (cpu_beat) nb++;
      if (i >= 7) chk(cmd == 4'b0111 && !cpu_busy, "R9 no command after dropped strobe", cmd, 4'b0111);
    end
    chk(nb == 4, "R9 single burst", nb, 4);
    access(1, 13'd0, 2'd3, 9'd0, 3, 4'b0011);  // R9 bank3 never opened

    // R8: CAS latency 3
    cfg_cas3 = 1;
    access(0, 13'd5, 2'd1, 9'd2, 4, 4'b0101);
    cfg_cas3 = 0;

    // R4: programmed tRCD/tRP
    cfg_trcd = 4'd3; cfg_trp = 4'd3;
    access(0, 13'd9, 2'd2, 9'd5, 9, 4'b0010);
    cfg_trcd = 4'd2; cfg_trp = 4'd2;

    // R10: refresh waits for the burst, then precharge-all and refresh
    @(negedge clk);
    cpu_start = 1; cpu_write = 0; cpu_addr = {13'd5, 2'd1, 9'd0};
    @(negedge clk);
    cpu_start = 0; ref_req = 1;
    nb = 0;
    for (int i = 0; i < 20; i++) begin
      if (cmd == 4'b0010) break;
      if (cpu_beat) nb++;
      @(negedge clk);
    end
    chk(cmd == 4'b0010 && sd_addr[10], "R10 precharge all", cmd, 4'b0010);
    chk(nb == 4, "R10 refresh after burst", nb, 4);
    @(negedge clk);
    chk(cmd == 4'b0111, "R10 tRP gap", cmd, 4'b0111);
    @(negedge clk);
    chk(cmd == 4'b0001 && ref_ack, "R10 auto refresh", cmd, 4'b0001);
    ref_req = 0;
    while (cpu_busy) @(negedge clk);
    access(0, 13'd5, 2'd0, 9'd1, 5, 4'b0011);  // R10 bank0 closed by refresh
    access(0, 13'd5, 2'd1, 9'd1, 5, 4'b0011);  // R10 bank1 closed by refresh

    // R10: refresh wins over a simultaneous strobe
    @(negedge clk);
    ref_req = 1; cpu_start = 1; cpu_write = 0; cpu_addr = {13'd5, 2'd0, 9'd0};
    @(negedge clk);
    cpu_start = 0;
    chk(cmd == 4'b0010 && sd_addr[10], "R10 refresh priority", cmd, 4'b0010);
    ref_req = 0;
    while (cpu_busy) @(negedge clk);
    access(0, 13'd5, 2'd0, 9'd1, 5, 4'b0011);  // strobe was dropped, bank closed

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule